// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit takes the 32-bit word of a single-register load or store and works out everything the memory stage needs before the access starts. It produces the access address, whether the transfer is a byte or a word, whether it is a load or a store, and whether the access must run with user-level permission. It also produces the updated base value and a strobe that says whether the register file should take it. The caller supplies the instruction word, the current base register contents, the contents of the offset register, the address of the instruction and the carry flag. The register file, the bus side and any data alignment are handled outside the unit.

The offset is either a 12-bit unsigned constant or a register passed through a barrel shifter. The shift amount is a 5-bit constant taken from the instruction. The offset is added to or subtracted from the base, with wrap-around. The access uses either the adjusted address (pre-indexed) or the untouched base (post-indexed). Writeback follows the indexing mode, the writeback bit and a load-onto-base exception. A register-offset word with bit 4 set is flagged as undefined.

The outputs are combinational when `REG_OUT` is 0. With the default of 1 they pass through one register stage, so each result appears one clock after its inputs.

Top module: `ldst_addr_unit`

## Requirements
- R1: `load_o` follows instruction bit 20 (1 = load) and `byte_o` follows bit 22 (1 = byte transfer).
- R2: When bit 25 is 0, the offset is the unsigned value in bits 11:0.
- R3: When bit 25 is 1, the offset is `index_i` shifted by the amount in bits 11:7. Bits 6:5 select the shift: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. This holds for amounts 1 to 31.
- R4: A shift amount of 0 has special meanings. Logical left by 0 leaves the value unchanged. Logical right by 0 gives zero. Arithmetic right by 0 fills all 32 bits with bit 31. Rotate right by 0 shifts right by one and inserts `carry_i` at bit 31.
- R5: When the base register number (bits 19:16) is 15, the base value is `pc_i + 8` and `base_i` is ignored.
- R6: The adjusted address is base + offset when bit 23 is 1, and base - offset when it is 0, both modulo 2^32.
- R7: When bit 24 is 1 (pre-index), `addr_o` is the adjusted address. When bit 24 is 0 (post-index), `addr_o` is the base value.
- R8: `wb_data_o` is always the adjusted address. `wb_en_o` is 1 for post-index, and for pre-index only when bit 21 is 1.
- R9: A load whose base register equals its transfer register (bits 15:12) never asserts `wb_en_o`.
- R10: `user_o` is 1 exactly when bit 24 is 0 and bit 21 is 1.
- R11: `undef_o` is 1 exactly when bits 25 and 4 are both 1. An undefined word never asserts `wb_en_o`.
- R12: With `REG_OUT` = 1, every output shows the result for the inputs sampled at the previous rising edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| instr_i | input | 32 | Transfer instruction word |
| base_i | input | 32 | Contents of the base register |
| index_i | input | 32 | Contents of the offset register |
| pc_i | input | 32 | Address of the instruction |
| carry_i | input | 1 | Current carry flag, used by rotate-by-zero |
| addr_o | output | 32 | Memory access address |
| byte_o | output | 1 | 1 = byte transfer, 0 = word |
| load_o | output | 1 | 1 = load, 0 = store |
| user_o | output | 1 | Access must use user-level permission |
| wb_data_o | output | 32 | New base register value |
| wb_en_o | output | 1 | Write `wb_data_o` back to the base register |
| undef_o | output | 1 | Instruction word is an undefined encoding |

## Verification
On every cycle, the assertions check the decoded flags, the user-access rule, the undefined flag and its blocking of writeback, and the load-onto-base suppression. They also check that a post-indexed access with a general base register uses the base unchanged, and that a pre-indexed writeback equals the access address. Only the bench's scenarios can show the arithmetic. This covers each shift type with normal and zero amounts, the carry fed into the rotate-by-zero case, the program-counter base, and subtraction that wraps below zero. The bench compares these against an independent model, for both directed words and a long run of random ones.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 4;
    localparam int SAMT_W = 5;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } sh_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic            is_byte;
        logic            is_load;
        logic            user;
        logic [XLEN-1:0] wb_data;
        logic            wb_en;
        logic            undef;
    } ldst_res_t;

endpackage

// File: rtl/ldst_shifter.sv
module ldst_shifter
    import ldst_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int A_W = SAMT_W
) (
    input  logic [W-1:0]   val_i,
    input  sh_kind_e       kind_i,
    input  logic [A_W-1:0] amt_i,
    input  logic           carry_i,
    output logic [W-1:0]   res_o
);

    localparam int DW = 2 * W;

    logic          zero_amt;
    logic [DW-1:0] rot_src;

    assign zero_amt = (amt_i == '0);
    assign rot_src  = {val_i, val_i};

    always_comb begin
        unique case (kind_i)
            SH_LSL: res_o = val_i << amt_i;
            SH_LSR: res_o = zero_amt ? '0 : (val_i >> amt_i);
            SH_ASR: res_o = zero_amt ? {W{val_i[W-1]}}
                                     : W'($signed(val_i) >>> amt_i);
            SH_ROR: begin
                if (zero_amt) begin
                    res_o = {carry_i, val_i[W-1:1]};
                end else begin
                    res_o = W'(rot_src >> amt_i);
                end
            end
            default: res_o = val_i;
        endcase
    end

endmodule

// File: rtl/ldst_addr_calc.sv
module ldst_addr_calc
    import ldst_pkg::*;
#(
    parameter int W        = XLEN,
    parameter int PC_AHEAD = 8
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] pc_i,
    input  logic         base_is_pc_i,
    input  logic [W-1:0] offset_i,
    input  logic         up_i,
    input  logic         pre_i,
    output logic [W-1:0] adj_o,
    output logic [W-1:0] access_o
);

    logic [W-1:0] base_eff;

    always_comb begin
        base_eff = base_is_pc_i ? (pc_i + W'(PC_AHEAD)) : base_i;
        adj_o    = up_i ? (base_eff + offset_i) : (base_eff - offset_i);
        access_o = pre_i ? adj_o : base_eff;
    end

endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit
    import ldst_pkg::*;
#(
    parameter bit REG_OUT  = 1'b1,
    parameter int PC_AHEAD = 8,
    parameter int PC_REG   = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] index_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            carry_i,
    output logic [XLEN-1:0] addr_o,
    output logic            byte_o,
    output logic            load_o,
    output logic            user_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic            wb_en_o,
    output logic            undef_o
);

    localparam int IMM_W = 12;

    // instruction fields
    logic              f_load, f_wb, f_byte, f_up, f_pre, f_regofs, f_bit4;
    logic [RIDX_W-1:0] f_rn, f_rd;
    logic [SAMT_W-1:0] f_amt;
    sh_kind_e          f_kind;

    assign f_load   = instr_i[20];
    assign f_wb     = instr_i[21];
    assign f_byte   = instr_i[22];
    assign f_up     = instr_i[23];
    assign f_pre    = instr_i[24];
    assign f_regofs = instr_i[25];
    assign f_bit4   = instr_i[4];
    assign f_rn     = instr_i[19:16];
    assign f_rd     = instr_i[15:12];
    assign f_amt    = instr_i[11:7];
    assign f_kind   = sh_kind_e'(instr_i[6:5]);

    logic [XLEN-1:0] shifted, offset, adj_addr, acc_addr;

    ldst_shifter #(.W(XLEN), .A_W(SAMT_W)) u_shift (
        .val_i   (index_i),
        .kind_i  (f_kind),
        .amt_i   (f_amt),
        .carry_i (carry_i),
        .res_o   (shifted)
    );

    assign offset = f_regofs ? shifted : XLEN'(instr_i[IMM_W-1:0]);

    ldst_addr_calc #(.W(XLEN), .PC_AHEAD(PC_AHEAD)) u_addr (
        .base_i       (base_i),
        .pc_i         (pc_i),
        .base_is_pc_i (f_rn == RIDX_W'(PC_REG)),
        .offset_i     (offset),
        .up_i         (f_up),
        .pre_i        (f_pre),
        .adj_o        (adj_addr),
        .access_o     (acc_addr)
    );

    ldst_res_t res_d, res_q;

    always_comb begin
        res_d         = '0;
        res_d.addr    = acc_addr;
        res_d.is_byte = f_byte;
        res_d.is_load = f_load;
        res_d.user    = !f_pre && f_wb;
        res_d.undef   = f_regofs && f_bit4;
        res_d.wb_data = adj_addr;
        res_d.wb_en   = (!f_pre || f_wb)
                      && !(f_load && (f_rn == f_rd))
                      && !(f_regofs && f_bit4);
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign addr_o    = res_q.addr;
    assign byte_o    = res_q.is_byte;
    assign load_o    = res_q.is_load;
    assign user_o    = res_q.user;
    assign wb_data_o = res_q.wb_data;
    assign wb_en_o   = res_q.wb_en;
    assign undef_o   = res_q.undef;

endmodule

// File: rtl/ldst_addr_unit_chk.sv
module ldst_addr_unit_chk
    import ldst_pkg::*;
#(
    parameter bit REG_OUT = 1'b1,
    parameter int PC_REG  = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] instr_i,
    input logic [XLEN-1:0] base_i,
    input logic [XLEN-1:0] addr_o,
    input logic            byte_o,
    input logic            load_o,
    input logic            user_o,
    input logic [XLEN-1:0] wb_data_o,
    input logic            wb_en_o,
    input logic            undef_o
);

    generate
        if (REG_OUT) begin : g_chk
            logic armed_q;
            always_ff @(posedge clk) begin
                if (!rst_n) armed_q <= 1'b0;
                else        armed_q <= 1'b1;
            end

            a_r1_flags: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                (load_o == $past(instr_i[20])) && (byte_o == $past(instr_i[22])));

            a_r10_user_access: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                user_o == ($past(!instr_i[24] && instr_i[21])));

            a_r11_undef_flag: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                undef_o == $past(instr_i[25] && instr_i[4]));

            a_r11_undef_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
                undef_o |-> !wb_en_o);

            a_r9_load_base_eq_dest: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                (load_o && $past(instr_i[19:16] == instr_i[15:12])) |-> !wb_en_o);

            a_r7_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                $past(!instr_i[24] && (instr_i[19:16] != 4'(PC_REG))) |-> (addr_o == $past(base_i)));

            a_r8_pre_wb_matches_addr: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                ($past(instr_i[24]) && wb_en_o) |-> (wb_data_o == addr_o));

            a_r8_post_wb_on: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                $past(!instr_i[24] && !instr_i[20] && !(instr_i[25] && instr_i[4])) |-> wb_en_o);

            a_r12_reset_clear: assert property (@(posedge clk)
                $past(!rst_n) |-> (!wb_en_o && !undef_o && !user_o && addr_o == '0));
        end
    endgenerate

endmodule

bind ldst_addr_unit ldst_addr_unit_chk #(.REG_OUT(REG_OUT), .PC_REG(PC_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .base_i    (base_i),
    .addr_o    (addr_o),
    .byte_o    (byte_o),
    .load_o    (load_o),
    .user_o    (user_o),
    .wb_data_o (wb_data_o),
    .wb_en_o   (wb_en_o),
    .undef_o   (undef_o)
);

// File: tb/tb_ldst_addr_unit.sv
`timescale 1ns/1ps
module tb_ldst_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0, base_i = '0, index_i = '0, pc_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] addr_o, wb_data_o;
    logic        byte_o, load_o, user_o, wb_en_o, undef_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ldst_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .base_i(base_i),
        .index_i(index_i), .pc_i(pc_i), .carry_i(carry_i),
        .addr_o(addr_o), .byte_o(byte_o), .load_o(load_o), .user_o(user_o),
        .wb_data_o(wb_data_o), .wb_en_o(wb_en_o), .undef_o(undef_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit l, input bit w, input bit b, input bit u,
                                       input bit p, input bit i, input int rn, input int rd,
                                       input logic [11:0] low);
        logic [31:0] x;
        x = 32'hE400_0000;
        x[25] = i; x[24] = p; x[23] = u; x[22] = b; x[21] = w; x[20] = l;
        x[19:16] = rn[3:0]; x[15:12] = rd[3:0]; x[11:0] = low;
        return x;
    endfunction

    // behavioural reference
    function automatic logic [31:0] ref_offset(input logic [31:0] ins, input logic [31:0] rm, input bit c);
        int amt;
        longint unsigned v;
        if (!ins[25]) return {20'd0, ins[11:0]};
        amt = int'(ins[11:7]);
        case (ins[6:5])
            2'd0: return rm << amt;
            2'd1: return (amt == 0) ? 32'd0 : rm >> amt;
            2'd2: begin
                if (amt == 0) amt = 32;
                v = {{32{rm[31]}}, rm};
                return v[31:0] >> 0 == 0 && amt == 32 ? 32'd0 : 32'(v >> amt);
            end
            default: begin
                if (amt == 0) return {c, rm[31:1]};
                v = {rm, rm};
                return 32'(v >> amt);
            end
        endcase
    endfunction

    task automatic apply(input string tag, input logic [31:0] ins, input logic [31:0] base,
                         input logic [31:0] rm, input logic [31:0] pc, input bit c);
        logic [31:0] b, ofs, adj, acc;
        bit wbe, und;
        instr_i = ins; base_i = base; index_i = rm; pc_i = pc; carry_i = c;
        b   = (ins[19:16] == 4'd15) ? pc + 32'd8 : base;
        ofs = ref_offset(ins, rm, c);
        adj = ins[23] ? b + ofs : b - ofs;
        acc = ins[24] ? adj : b;
        und = ins[25] && ins[4];
        wbe = (!ins[24] || ins[21]) && !(ins[20] && ins[19:16] == ins[15:12]) && !und;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R7 addr"}, addr_o, acc);
        chk("R1 load", {31'd0, load_o}, {31'd0, ins[20]});
        chk("R1 byte", {31'd0, byte_o}, {31'd0, ins[22]});
        chk("R10 user", {31'd0, user_o}, {31'd0, !ins[24] && ins[21]});
        chk("R11 undef", {31'd0, undef_o}, {31'd0, und});
        chk("R8/R9 wb_en", {31'd0, wb_en_o}, {31'd0, wbe});
        chk("R8 wb_data", wb_data_o, adj);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 reset addr", addr_o, 32'd0);
        chk("R12 reset wb_en", {31'd0, wb_en_o}, 32'd0);
        chk("R12 reset undef", {31'd0, undef_o}, 32'd0);
        rst_n = 1'b1;

        // R2 immediate, pre-index add, no writeback
        apply("R2", mk(1,0,0,1,1,0,1,2,12'h123), 32'h1000, 0, 0, 0);
        // R6 subtract wrapping, byte store, pre-index writeback
        apply("R6", mk(0,1,1,0,1,0,3,4,12'h200), 32'h100, 0, 0, 0);
        // post-index, no user flag
        apply("R8 post", mk(1,0,0,1,0,0,5,6,12'h010), 32'h4000, 0, 0, 0);
        // R10 post-index with bit 21
        apply("R10", mk(1,1,0,1,0,0,5,6,12'h010), 32'h4000, 0, 0, 0);
        // R9 load onto base, then store with same registers
        apply("R9 load", mk(1,1,0,1,1,0,7,7,12'h004), 32'h2000, 0, 0, 0);
        apply("R9 store", mk(0,1,0,1,1,0,7,7,12'h004), 32'h2000, 0, 0, 0);
        // R5 base is program counter, base_i ignored
        apply("R5", mk(1,0,0,1,1,0,15,1,12'h004), 32'hDEAD_BEEF, 0, 32'h8000, 0);
        // R3 shifted register offsets
        apply("R3 lsl", mk(1,0,0,1,1,1,1,2,{5'd3,2'd0,1'b0,4'd9}), 32'h100, 32'h11, 0, 0);
        apply("R3 lsr", mk(1,0,0,1,1,1,1,2,{5'd4,2'd1,1'b0,4'd9}), 32'h100, 32'hF0, 0, 0);
        apply("R3 asr", mk(1,0,0,1,1,1,1,2,{5'd8,2'd2,1'b0,4'd9}), 32'h100, 32'h8000_0000, 0, 0);
        apply("R3 ror", mk(1,0,0,0,1,1,1,2,{5'd8,2'd3,1'b0,4'd9}), 32'h100, 32'h0000_00AB, 0, 0);
        // R4 zero amounts
        apply("R4 lsl0", mk(1,0,0,1,1,1,1,2,{5'd0,2'd0,1'b0,4'd9}), 32'h100, 32'h55, 0, 0);
        apply("R4 lsr0", mk(1,0,0,1,1,1,1,2,{5'd0,2'd1,1'b0,4'd9}), 32'h100, 32'hFFFF_FFFF, 0, 0);
        apply("R4 asr0", mk(1,0,0,1,1,1,1,2,{5'd0,2'd2,1'b0,4'd9}), 32'h100, 32'h8000_0001, 0, 0);
        apply("R4 ror0c1", mk(1,0,0,1,1,1,1,2,{5'd0,2'd3,1'b0,4'd9}), 32'h0, 32'h0000_0003, 0, 1);
        apply("R4 ror0c0", mk(1,0,0,1,1,1,1,2,{5'd0,2'd3,1'b0,4'd9}), 32'h0, 32'h0000_0003, 0, 0);
        // R11 undefined encoding
        apply("R11", mk(0,0,0,1,0,1,1,2,{5'd1,2'd0,1'b1,4'd9}), 32'h100, 32'h1, 0, 0);

        for (int k = 0; k < 300; k++) begin
            apply("rand", $urandom, $urandom, $urandom, $urandom, 1'($urandom));
        end

        // R12: reset mid-run clears outputs
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R12 reset again", addr_o | wb_data_o, 32'd0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule